// File: doc/BRIEF.md
# First-Fault Capture Registers

This block records the particulars of the first bus access that the surrounding logic flags as faulting. It stores the full address of that access, a one-hot code for the kind of access, and a packed word of transaction attributes. It then holds all three values unchanged, however many further faults arrive, until software re-arms it through a clear register. Software reads the three values, and writes the clear register, over a simple word-addressed register port.

Which accesses count as faults is decided upstream. The block only sees a strobe and its fields. Error interrupt status lives in another block and is not touched when capture is re-armed. Re-arming also zeroes the held values, so a type reading of zero always means that nothing is held. A strobe whose type field does not have exactly one bit set carries no legal access kind and is dropped.

Top module: `fault_capture_regs`

## Requirements
- R1: After reset, the address (offset 0x1024), type (0x1028) and attribute (0x102C) registers all read zero.
- R2: When nothing is held, a fault strobe with a legal type loads its address, type and attributes. The new values can be read from the cycle after the strobe.
- R3: The attribute register packs the transaction ID in bits 31:20, the route ID in bits 19:8 and the privilege ID in bits 7:0.
- R4: Type codes are one-hot in bits 5:0: 0x01 user execute, 0x02 user write, 0x04 user read, 0x08 supervisor execute, 0x10 supervisor write, 0x20 supervisor read, and 0 means no fault held. A strobe whose type field is zero or has more than one bit set is ignored.
- R5: While a fault is held, later fault strobes leave all three registers unchanged.
- R6: A write to offset 0x1030 with bit 0 set re-arms capture and zeroes all three registers from the next cycle. A write there with bit 0 clear has no effect.
- R7: A legal fault strobe in the same cycle as a re-arm write is captured, and its values are held afterwards.
- R8: Writes to offsets 0x1024, 0x1028 and 0x102C are ignored.
- R9: Reads return data in the same cycle, combinationally. Offset 0x1030 and any unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault strobe, one cycle per faulting access |
| flt_addr | input | 32 | Address of the faulting access |
| flt_kind | input | 6 | One-hot access kind of the faulting access |
| flt_txn | input | 12 | Transaction ID of the faulting access |
| flt_route | input | 12 | Route ID of the faulting access |
| flt_priv | input | 8 | Privilege ID of the faulting access |
| reg_sel | input | 1 | Register port access strobe |
| reg_wr | input | 1 | Register port write (1) or read (0) |
| reg_addr | input | 16 | Byte offset of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle |

## Verification
A fault strobe or a re-arm write takes effect at the clock edge that samples it, so its result can be read one cycle later. Read data reflects the registers combinationally with no further delay. The bench drives each stimulus for exactly one edge and advances a behavioural model at that same edge. After the edge it reads all three registers through the port, between edges, and compares them with the model. No result is sampled before the edge that produces it.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  // Register offsets: software decodes these, so they are fixed.
  localparam int unsigned OFS_FADDR = 32'h0000_1024;
  localparam int unsigned OFS_FTYPE = 32'h0000_1028;
  localparam int unsigned OFS_FATTR = 32'h0000_102C;
  localparam int unsigned OFS_REARM = 32'h0000_1030;

  // Bit of the clear register that re-arms capture.
  localparam int unsigned REARM_BIT = 0;

  // Selects which register drives the read data.
  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_FADDR = 2'd1,
    RSEL_FTYPE = 2'd2,
    RSEL_FATTR = 2'd3
  } rsel_e;

  // True when exactly one bit of the value is set.
  function automatic logic single_hot(input logic [31:0] v);
    logic [31:0] low_cleared;
    low_cleared = v & (v - 32'd1);
    return (v != 32'd0) && (low_cleared == 32'd0);
  endfunction

  // Compares a register-port offset against a fixed register offset.
  function automatic logic ofs_match(input logic [31:0] ofs, input int unsigned target);
    return ofs == target[31:0];
  endfunction

endpackage

// File: rtl/fcap_decode.sv
module fcap_decode
  import fcap_pkg::*;
#(
  parameter int unsigned BUS_AW = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output rsel_e             rd_pick,
  output logic              rearm,
  output logic              wr_to_ro
);

  logic [31:0] ofs_ext;
  logic        hit_faddr;
  logic        hit_ftype;
  logic        hit_fattr;
  logic        hit_rearm;
  logic        is_write;
  logic        is_read;

  assign ofs_ext   = 32'(reg_addr);
  assign hit_faddr = ofs_match(ofs_ext, OFS_FADDR);
  assign hit_ftype = ofs_match(ofs_ext, OFS_FTYPE);
  assign hit_fattr = ofs_match(ofs_ext, OFS_FATTR);
  assign hit_rearm = ofs_match(ofs_ext, OFS_REARM);
  assign is_write  = reg_sel && reg_wr;
  assign is_read   = reg_sel && !reg_wr;

  // Only bit 0 of a write to the clear register re-arms capture.
  assign rearm    = is_write && hit_rearm && reg_wdata[REARM_BIT];
  // Writes that reach a capture register; they are decoded and then dropped.
  assign wr_to_ro = is_write && (hit_faddr || hit_ftype || hit_fattr);

  always_comb begin
    rd_pick = RSEL_NONE;
    if (is_read) begin
      if (hit_faddr)      rd_pick = RSEL_FADDR;
      else if (hit_ftype) rd_pick = RSEL_FTYPE;
      else if (hit_fattr) rd_pick = RSEL_FATTR;
      else                rd_pick = RSEL_NONE;
    end
  end

  // R8: a write is either a re-arm or a dropped capture write, never both.
  assert_write_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rearm && wr_to_ro));

  // R9: a write never selects read data.
  assert_no_read_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |-> (rd_pick == RSEL_NONE));

endmodule

// File: rtl/fcap_hold.sv
module fcap_hold
  import fcap_pkg::*;
#(
  parameter int unsigned FADDR_W = 32,
  parameter int unsigned TYPE_W  = 6,
  parameter int unsigned TXN_W   = 12,
  parameter int unsigned ROUTE_W = 12,
  parameter int unsigned PRIV_W  = 8,
  localparam int unsigned ATTR_W = TXN_W + ROUTE_W + PRIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  input  logic [FADDR_W-1:0] flt_addr,
  input  logic [TYPE_W-1:0]  flt_kind,
  input  logic [TXN_W-1:0]   flt_txn,
  input  logic [ROUTE_W-1:0] flt_route,
  input  logic [PRIV_W-1:0]  flt_priv,
  input  logic               rearm,
  input  logic               wr_to_ro,
  output logic [FADDR_W-1:0] cap_addr,
  output logic [TYPE_W-1:0]  cap_type,
  output logic [ATTR_W-1:0]  cap_attr,
  output logic               held,
  output logic               take
);

  // Transaction ID at the top, privilege ID at the bottom.
  function automatic logic [ATTR_W-1:0] pack_attr(
    input logic [TXN_W-1:0]   t,
    input logic [ROUTE_W-1:0] r,
    input logic [PRIV_W-1:0]  p
  );
    return {t, r, p};
  endfunction

  logic legal_kind;
  logic armed;

  assign legal_kind = single_hot(32'(flt_kind));
  // Re-arming in the same cycle frees the holder for the incoming fault.
  assign armed      = !held || rearm;
  assign take       = flt_valid && legal_kind && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_type <= '0;
      cap_attr <= '0;
      held     <= 1'b0;
    end else if (take) begin
      cap_addr <= flt_addr;
      cap_type <= flt_kind;
      cap_attr <= pack_attr(flt_txn, flt_route, flt_priv);
      held     <= 1'b1;
    end else if (rearm) begin
      cap_addr <= '0;
      cap_type <= '0;
      cap_attr <= '0;
      held     <= 1'b0;
    end
  end

  // R2: with nothing held, a legal fault is loaded by the next cycle.
  assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && legal_kind && !held) |=>
      (cap_addr == $past(flt_addr) && cap_type == $past(flt_kind) && held));

  // R3: attribute fields land in their packed positions.
  assert_attr_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && legal_kind && !held) |=>
      (cap_attr[PRIV_W-1:0] == $past(flt_priv) &&
       cap_attr[ATTR_W-1:ATTR_W-TXN_W] == $past(flt_txn)));

  // R4: the held type is one-hot, and zero exactly when nothing is held.
  assert_type_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_type) && (held == (cap_type != '0)));

  // R5: while held and not re-armed, nothing changes.
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rearm) |=> ($stable(cap_addr) && $stable(cap_type) && $stable(cap_attr)));

  // R6: a re-arm with no competing fault clears everything.
  assert_rearm_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !(flt_valid && legal_kind)) |=>
      (cap_addr == '0 && cap_type == '0 && cap_attr == '0 && !held));

  // R7: a fault that coincides with a re-arm wins.
  assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && flt_valid && legal_kind) |=> (held && cap_addr == $past(flt_addr)));

  // R8: a dropped write on its own moves nothing.
  assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_to_ro && !take) |=> ($stable(cap_addr) && $stable(cap_type) && $stable(cap_attr)));

endmodule

// File: rtl/fcap_rdmux.sv
module fcap_rdmux
  import fcap_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FADDR_W = 32,
  parameter int unsigned TYPE_W  = 6,
  parameter int unsigned ATTR_W  = 32
) (
  input  rsel_e              rd_pick,
  input  logic [FADDR_W-1:0] cap_addr,
  input  logic [TYPE_W-1:0]  cap_type,
  input  logic [ATTR_W-1:0]  cap_attr,
  output logic [DATA_W-1:0]  rdata
);

  always_comb begin
    unique case (rd_pick)
      RSEL_FADDR: rdata = DATA_W'(cap_addr);
      RSEL_FTYPE: rdata = DATA_W'(cap_type);
      RSEL_FATTR: rdata = DATA_W'(cap_attr);
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/fault_capture_regs.sv
module fault_capture_regs
  import fcap_pkg::*;
#(
  parameter int unsigned BUS_AW  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FADDR_W = 32,
  parameter int unsigned TYPE_W  = 6,
  parameter int unsigned TXN_W   = 12,
  parameter int unsigned ROUTE_W = 12,
  parameter int unsigned PRIV_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  input  logic [FADDR_W-1:0] flt_addr,
  input  logic [TYPE_W-1:0]  flt_kind,
  input  logic [TXN_W-1:0]   flt_txn,
  input  logic [ROUTE_W-1:0] flt_route,
  input  logic [PRIV_W-1:0]  flt_priv,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [BUS_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata
);

  localparam int unsigned ATTR_W = TXN_W + ROUTE_W + PRIV_W;

  // Named internal events, shared with the assertions.
  rsel_e              rd_pick;
  logic               rearm;
  logic               wr_to_ro;
  logic               held;
  logic               take;
  logic [FADDR_W-1:0] cap_addr;
  logic [TYPE_W-1:0]  cap_type;
  logic [ATTR_W-1:0]  cap_attr;

  fcap_decode #(
    .BUS_AW (BUS_AW),
    .DATA_W (DATA_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_pick   (rd_pick),
    .rearm     (rearm),
    .wr_to_ro  (wr_to_ro)
  );

  fcap_hold #(
    .FADDR_W (FADDR_W),
    .TYPE_W  (TYPE_W),
    .TXN_W   (TXN_W),
    .ROUTE_W (ROUTE_W),
    .PRIV_W  (PRIV_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr),
    .flt_kind  (flt_kind),
    .flt_txn   (flt_txn),
    .flt_route (flt_route),
    .flt_priv  (flt_priv),
    .rearm     (rearm),
    .wr_to_ro  (wr_to_ro),
    .cap_addr  (cap_addr),
    .cap_type  (cap_type),
    .cap_attr  (cap_attr),
    .held      (held),
    .take      (take)
  );

  fcap_rdmux #(
    .DATA_W  (DATA_W),
    .FADDR_W (FADDR_W),
    .TYPE_W  (TYPE_W),
    .ATTR_W  (ATTR_W)
  ) u_rdmux (
    .rd_pick  (rd_pick),
    .cap_addr (cap_addr),
    .cap_type (cap_type),
    .cap_attr (cap_attr),
    .rdata    (reg_rdata)
  );

  // R5: a second legal fault while held is never taken.
  assert_no_retake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rearm) |-> !take);

  // R9: the clear register reads as zero.
  assert_rearm_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr == BUS_AW'(OFS_REARM)) |-> (reg_rdata == '0));

endmodule

// File: tb/test_fault_capture_regs.sv
module test_fault_capture_regs;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [31:0] flt_addr = '0;
  logic [5:0]  flt_kind = '0;
  logic [11:0] flt_txn = '0;
  logic [11:0] flt_route = '0;
  logic [7:0]  flt_priv = '0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state.
  logic [31:0] m_addr = '0;
  logic [31:0] m_type = '0;
  logic [31:0] m_attr = '0;
  bit          m_held = 0;

  always #(PERIOD/2) clk = ~clk;

  fault_capture_regs i_fault_capture_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr),
    .flt_kind  (flt_kind),
    .flt_txn   (flt_txn),
    .flt_route (flt_route),
    .flt_priv  (flt_priv),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  task automatic check_reg(input logic [15:0] ofs, input logic [31:0] exp, input string tag);
    reg_sel  = 1'b1;
    reg_wr   = 1'b0;
    reg_addr = ofs;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s offset %h actual %h expected %h", tag, ofs, reg_rdata, exp);
    end
    reg_sel = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    check_reg(16'h1024, m_addr, tag);
    check_reg(16'h1028, m_type, tag);
    check_reg(16'h102C, m_attr, tag);
  endtask

  // One clock of stimulus: drive after a falling edge, advance the model at
  // the rising edge, then read everything back before the next rising edge.
  task automatic step(input bit fv, input logic [31:0] fa, input logic [5:0] fk,
                      input logic [11:0] ft, input logic [11:0] fr, input logic [7:0] fp,
                      input bit wr_en, input logic [15:0] wa, input logic [31:0] wd,
                      input string tag);
    bit legal;
    bit rearm_now;
    @(negedge clk);
    flt_valid = fv; flt_addr = fa; flt_kind = fk;
    flt_txn = ft; flt_route = fr; flt_priv = fp;
    reg_sel = wr_en; reg_wr = wr_en; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    legal     = ($countones(fk) == 1);
    rearm_now = wr_en && (wa == 16'h1030) && wd[0];
    if (fv && legal && (!m_held || rearm_now)) begin
      m_addr = fa;
      m_type = 32'(fk);
      m_attr = (32'(ft) << 20) | (32'(fr) << 8) | 32'(fp);
      m_held = 1;
    end else if (rearm_now) begin
      m_addr = '0; m_type = '0; m_attr = '0; m_held = 0;
    end
    #1;
    flt_valid = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: everything zero after reset.
    compare_all("R1");
    // R9: clear register and an unmapped offset read as zero.
    check_reg(16'h1030, 32'h0, "R9");
    check_reg(16'h1000, 32'h0, "R9");
    check_reg(16'h1020, 32'h0, "R9");

    // R2, R3: first legal fault is captured with packed attributes.
    step(1, 32'hDEAD_BEE0, 6'h04, 12'hABC, 12'h123, 8'h5A, 0, 16'h0, 32'h0, "R2");
    check_reg(16'h102C, 32'hABC1_235A, "R3");
    check_reg(16'h1030, 32'h0, "R9");

    // R5: later faults do not overwrite.
    step(1, 32'h1111_2222, 6'h20, 12'h001, 12'h002, 8'h03, 0, 16'h0, 32'h0, "R5");
    step(1, 32'h3333_4444, 6'h01, 12'hFFF, 12'hFFF, 8'hFF, 0, 16'h0, 32'h0, "R5");

    // R8: writes to the capture registers are dropped.
    step(0, 32'h0, 6'h0, 12'h0, 12'h0, 8'h0, 1, 16'h1024, 32'hFFFF_FFFF, "R8");
    step(0, 32'h0, 6'h0, 12'h0, 12'h0, 8'h0, 1, 16'h1028, 32'h0000_0001, "R8");
    step(0, 32'h0, 6'h0, 12'h0, 12'h0, 8'h0, 1, 16'h102C, 32'h0000_0000, "R8");

    // R6: clear write with bit 0 low does nothing, bit 0 high zeroes.
    step(0, 32'h0, 6'h0, 12'h0, 12'h0, 8'h0, 1, 16'h1030, 32'hFFFF_FFFE, "R6");
    step(0, 32'h0, 6'h0, 12'h0, 12'h0, 8'h0, 1, 16'h1030, 32'h0000_0001, "R6");

    // R4: illegal type codes are ignored while armed.
    step(1, 32'h5555_0000, 6'h03, 12'h010, 12'h020, 8'h30, 0, 16'h0, 32'h0, "R4");
    step(1, 32'h6666_0000, 6'h00, 12'h010, 12'h020, 8'h30, 0, 16'h0, 32'h0, "R4");
    step(1, 32'h7777_0000, 6'h3F, 12'h010, 12'h020, 8'h30, 0, 16'h0, 32'h0, "R4");

    // R2: capture of a supervisor write after re-arm.
    step(1, 32'h8000_0004, 6'h10, 12'h321, 12'h654, 8'h87, 0, 16'h0, 32'h0, "R2");

    // R7: fault coincident with re-arm is captured.
    step(1, 32'h9000_0008, 6'h08, 12'h0F0, 12'h00F, 8'hC3, 1, 16'h1030, 32'h1, "R7");
    step(1, 32'hA000_000C, 6'h02, 12'h111, 12'h222, 8'h33, 0, 16'h0, 32'h0, "R5");

    // R4: every legal code, each after a re-arm.
    for (int k = 0; k < 6; k++) begin
      step(0, 32'h0, 6'h0, 12'h0, 12'h0, 8'h0, 1, 16'h1030, 32'h1, "R6");
      step(1, 32'h0100_0000 + 32'(k), 6'(1 << k), 12'(k), 12'(k + 7), 8'(k * 3),
           0, 16'h0, 32'h0, "R4");
    end

    // R7: re-arm coinciding with an illegal fault just clears.
    step(1, 32'hBBBB_0000, 6'h06, 12'h0, 12'h0, 8'h0, 1, 16'h1030, 32'h1, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule